// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block runs the addressing step that opens every I2C transfer. A client hands it a target address of up to ten bits and a read/write bit. The block first decides whether the address is legal. It then drives a byte-level engine below it: one START command, followed by one or two address-byte writes. It reports a single status back to the client.

The addressing mode follows from the numeric value of the address. Values below 0x80 are sent as one 7-bit address byte. Values from 0x80 to 0x3FF are sent as two bytes that begin with the 10-bit prefix. Values at 0x400 or above are refused. So is any 7-bit value whose bits would look like that prefix. Every write the block issues leaves the stop flag clear, so the bus stays held for the data phase that follows.

Both sides use handshakes. On the client side, a request is taken only while `req_ready` is high. Completion is a one-cycle `done` pulse that carries `status`. On the engine side, the block raises a command with a valid/ready pair. It then waits for the engine's response pulse before it issues the next command.

Top module: `i2c_addr_seq`

## Requirements
- R1: For an address below 0x80 that is not rejected, the commands are START followed by exactly one write of the byte {addr[6:0], rw}.
- R2: A 7-bit address with addr[6:3] all ones (0x78 to 0x7F) ends with status INVALID (3). No engine command is issued.
- R3: For an address from 0x80 to 0x3FF, the first write after START carries the upper byte of the word 0xF000 | (addr<<1) | rw, which is {5'b11110, addr[9:7]}.
- R4: In 10-bit mode, the second write carries the lower byte {addr[6:0], rw}. The engine's response to that write becomes the final status.
- R5: If the engine answers NACK to the 10-bit upper byte, the sequence ends with status NACK and the lower byte is never sent.
- R6: An address of 0x400 or above ends with status INVALID (3) and no engine command.
- R7: The first engine command of every accepted legal request is START (op 0), and every later one is WRITE (op 1). The stop flag is 0 on every command.
- R8: Status values are OK=0, NACK=1, TIMEOUT=2, INVALID=3. `done` is high for exactly one cycle per request, and `status` is valid in that cycle.
- R9: A non-OK engine response (NACK=1 or TIMEOUT=2) at any step ends the sequence at once with that same status.
- R10: `req_ready` is high only when the block is idle. A request presented while it is busy has no effect on the commands or the result.
- R11: Only one engine command is outstanding at a time. A command holds its op and byte steady until it is accepted, and no command is raised while a response is awaited or while `done` is high.
- R12: After reset, `req_ready` is 1, and `done` and `eng_cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client presents a request |
| req_ready | output | 1 | Sequencer idle; a request is taken when both are high |
| req_addr | input | ADDR_W | Target address |
| req_rd | input | 1 | Read (1) or write (0) direction bit |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: OK=0, NACK=1, TIMEOUT=2, INVALID=3 |
| eng_cmd_valid | output | 1 | Command to the byte engine is valid |
| eng_cmd_ready | input | 1 | Engine accepts the command |
| eng_cmd_op | output | 1 | 0 = START, 1 = WRITE byte |
| eng_cmd_byte | output | 8 | Byte for a WRITE |
| eng_cmd_stop | output | 1 | Stop-after-byte flag (always 0 from this block) |
| eng_rsp_valid | input | 1 | Engine finished the outstanding command |
| eng_rsp_status | input | 2 | Engine result: OK=0, NACK=1, TIMEOUT=2 |

## Verification
The hardest case to reach from the ports is an early exit in the middle of a 10-bit sequence. The prefix byte has to be refused while the lower byte is still pending. That lower byte must then never appear on the command port. The bench's engine model follows a per-request script of responses indexed by command position. This lets a NACK or TIMEOUT land on exactly the START, the prefix byte or the lower byte. The bench then compares the full logged command list, not just the status. A second awkward case is a request held on the client port during a busy sequence with a different address. The bench checks that only the first address reaches the engine.

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rd,
  output logic              done,
  output logic [1:0]        status,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic              eng_cmd_op,
  output logic [7:0]        eng_cmd_byte,
  output logic              eng_cmd_stop,
  input  logic              eng_rsp_valid,
  input  logic [1:0]        eng_rsp_status
);

  localparam logic [1:0] ST_OK  = 2'd0;
  localparam logic [1:0] ST_BAD = 2'd3;
  localparam logic [ADDR_W-1:0] LIM7  = ADDR_W'(12'h080);
  localparam logic [ADDR_W-1:0] LIM10 = ADDR_W'(12'h400);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} state_t;
  typedef enum logic [1:0] {P_START, P_HI, P_LO} phase_t;

  state_t      st_q;
  phase_t      ph_q;
  logic [9:0]  addr_q;
  logic        rd_q, ten_q;
  logic [1:0]  stat_q;

  wire req_fire = req_valid && req_ready;
  wire ten_in   = req_addr >= LIM7;
  wire bad_in   = (req_addr >= LIM10) || (!ten_in && req_addr[6:3] == 4'hF);

  wire [7:0] hi_byte = {5'b11110, addr_q[9:7]};
  wire [7:0] lo_byte = {addr_q[6:0], rd_q};

  assign req_ready     = (st_q == S_IDLE);
  assign done          = (st_q == S_FIN);
  assign status        = stat_q;
  assign eng_cmd_valid = (st_q == S_ISSUE);
  assign eng_cmd_op    = (ph_q != P_START);
  assign eng_cmd_byte  = (ph_q == P_HI) ? hi_byte : (ph_q == P_LO) ? lo_byte : 8'h00;
  assign eng_cmd_stop  = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ph_q   <= P_START;
      addr_q <= '0;
      rd_q   <= 1'b0;
      ten_q  <= 1'b0;
      stat_q <= ST_OK;
    end else begin
      case (st_q)
        S_IDLE: if (req_fire) begin
          addr_q <= req_addr[9:0];
          rd_q   <= req_rd;
          ten_q  <= ten_in;
          ph_q   <= P_START;
          if (bad_in) begin
            stat_q <= ST_BAD;
            st_q   <= S_FIN;
          end else begin
            st_q   <= S_ISSUE;
          end
        end
        S_ISSUE: if (eng_cmd_ready) st_q <= S_WAIT;
        S_WAIT: if (eng_rsp_valid) begin
          if (eng_rsp_status != ST_OK) begin
            stat_q <= eng_rsp_status;
            st_q   <= S_FIN;
          end else begin
            case (ph_q)
              P_START: begin ph_q <= ten_q ? P_HI : P_LO; st_q <= S_ISSUE; end
              P_HI:    begin ph_q <= P_LO; st_q <= S_ISSUE; end
              default: begin stat_q <= ST_OK; st_q <= S_FIN; end
            endcase
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && !eng_cmd_ready |=> eng_cmd_valid && $stable(eng_cmd_byte) && $stable(eng_cmd_op));

  // R11
  no_cmd_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && eng_cmd_ready |=> !eng_cmd_valid);

  // R2 R6
  invalid_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && bad_in |=> done && status == ST_BAD && !eng_cmd_valid);

  // R9
  err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_WAIT && eng_rsp_valid && eng_rsp_status != ST_OK |=> done && status == $past(eng_rsp_status));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid || done) |-> !req_ready);

endmodule

// File: tb/i2c_addr_seq_tb.sv
module i2c_addr_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0;
  logic [10:0] req_addr = '0;
  logic req_ready, done, eng_cmd_valid, eng_cmd_op, eng_cmd_stop;
  logic [1:0] status;
  logic [7:0] eng_cmd_byte;
  logic eng_cmd_ready = 1'b0, eng_rsp_valid = 1'b0;
  logic [1:0] eng_rsp_status = 2'd0;

  always #2 clk = ~clk;

  i2c_addr_seq #(.ADDR_W(11)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd(req_rd), .done(done), .status(status),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_cmd_op(eng_cmd_op), .eng_cmd_byte(eng_cmd_byte), .eng_cmd_stop(eng_cmd_stop),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_status(eng_rsp_status));

  int errors = 0, checks = 0, cycles = 0;
  int ncmd = 0, base = 0, cnt = 0;
  bit pend = 0;
  logic [5:0] plan = '0;
  logic       lop [0:255];
  logic [7:0] lbyte [0:255];
  logic       lstop [0:255];

  always @(negedge clk) begin
    eng_cmd_ready <= 1'b0;
    eng_rsp_valid <= 1'b0;
    if (!rst_n) begin
      pend = 0;
    end else if (pend) begin
      if (cnt == 0) begin
        eng_rsp_valid  <= 1'b1;
        eng_rsp_status <= plan[2*(ncmd-base-1) +: 2];
        pend = 0;
      end else cnt--;
    end else if (eng_cmd_valid && !eng_cmd_ready) begin
      eng_cmd_ready <= 1'b1;
      lop[ncmd % 256]   = eng_cmd_op;
      lbyte[ncmd % 256] = eng_cmd_byte;
      lstop[ncmd % 256] = eng_cmd_stop;
      ncmd++;
      pend = 1;
      cnt = 2;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      summary();
    end
  end

  // run one request; if hold_busy, keep presenting 0x3FF while busy
  task automatic run(input logic [10:0] a, input logic rd, input logic [5:0] p,
                     input bit hold_busy, output logic [1:0] st, output int n);
    int k;
    bit seen;
    plan = p;
    base = ncmd;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_rd = rd;
    @(negedge clk);
    if (hold_busy) begin req_addr = 11'h3FF; req_rd = 1'b1; end
    else req_valid = 1'b0;
    seen = 0;
    st = 2'd0;
    for (k = 0; k < 300 && !seen; k++) begin
      if (done) begin seen = 1; st = status; end
      else @(negedge clk);
    end
    req_valid = 1'b0;
    chk(seen, "R8 done seen", seen, 1);
    @(negedge clk);
    chk(!done, "R8 done single cycle", done, 0);
    n = ncmd - base;
  endtask

  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {11'h050, 1'b0, 6'h00, 2'd0, 2'd2, 8'hA0, 8'h00},
    {11'h050, 1'b1, 6'h00, 2'd0, 2'd2, 8'hA1, 8'h00},
    {11'h021, 1'b0, 6'h04, 2'd1, 2'd2, 8'h42, 8'h00},
    {11'h077, 1'b1, 6'h00, 2'd0, 2'd2, 8'hEF, 8'h00},
    {11'h078, 1'b0, 6'h00, 2'd3, 2'd0, 8'h00, 8'h00},
    {11'h07F, 1'b1, 6'h00, 2'd3, 2'd0, 8'h00, 8'h00},
    {11'h080, 1'b0, 6'h00, 2'd0, 2'd3, 8'hF1, 8'h00},
    {11'h3FF, 1'b1, 6'h00, 2'd0, 2'd3, 8'hF7, 8'hFF},
    {11'h155, 1'b0, 6'h04, 2'd1, 2'd2, 8'hF2, 8'h00},
    {11'h2AA, 1'b1, 6'h10, 2'd1, 2'd3, 8'hF5, 8'h55},
    {11'h400, 1'b0, 6'h00, 2'd3, 2'd0, 8'h00, 8'h00},
    {11'h123, 1'b0, 6'h02, 2'd2, 2'd1, 8'h00, 8'h00},
    {11'h040, 1'b0, 6'h08, 2'd2, 2'd2, 8'h80, 8'h00}
  };

  initial begin
    logic [1:0] st;
    int n;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12 req_ready", req_ready, 1);
    chk(done == 1'b0, "R12 done", done, 0);
    chk(eng_cmd_valid == 1'b0, "R12 cmd_valid", eng_cmd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] a; logic rd; logic [5:0] p; logic [1:0] es; logic [1:0] en;
      logic [7:0] b1, b2;
      string tag;
      {a, rd, p, es, en, b1, b2} = VEC[i];
      tag = (es == 2'd3) ? "R2 R6 R8" : (p != 0) ? "R5 R9 R8" : (en == 2'd3) ? "R3 R4 R8" : "R1 R8";
      run(a, rd, p, 1'b0, st, n);
      chk(st == es, {tag, " status"}, st, es);
      chk(n == int'(en), {tag, " command count"}, n, en);
      for (int k = 0; k < n; k++) begin
        chk(lop[(base+k)%256] == (k != 0), "R7 op order", lop[(base+k)%256], k != 0);
        chk(lstop[(base+k)%256] == 1'b0, "R7 stop clear", lstop[(base+k)%256], 0);
      end
      if (n >= 2) chk(lbyte[(base+1)%256] == b1, (en == 2'd3) ? "R3 upper byte" : "R1 address byte",
                      lbyte[(base+1)%256], b1);
      if (n >= 3) chk(lbyte[(base+2)%256] == b2, "R4 lower byte", lbyte[(base+2)%256], b2);
    end

    // R10 request held while busy with another address is ignored
    run(11'h033, 1'b0, 6'h00, 1'b1, st, n);
    chk(st == 2'd0, "R10 status", st, 0);
    chk(n == 2, "R10 command count", n, 2);
    chk(lbyte[(base+1)%256] == 8'h66, "R10 byte unaffected", lbyte[(base+1)%256], 8'h66);
    chk(req_ready == 1'b1, "R10 ready again when idle", req_ready, 1);

    // R11 no command raised between acceptance and response
    run(11'h3C0, 1'b0, 6'h00, 1'b0, st, n);
    chk(n == 3 && st == 2'd0, "R11 one at a time", n, 3);
    chk(!eng_cmd_valid, "R11 idle after done", eng_cmd_valid, 0);

    summary();
  end
endmodule